// File: doc/BRIEF.md
# UART Transmit Empty Status Logic

This block produces the status flags and the transmit-empty interrupt request for a UART transmit path. In that path, a single holding register or a small FIFO sits in front of the shift register. It tracks how many characters wait ahead of the shift register. The occupancy goes up when software writes a character and down when the serializer loads one into its shift register. From that occupancy, the shift-busy input and the mode inputs, it derives a holding-empty flag, a transmitter-empty flag and an interrupt request. The serializer itself lies outside the block.

In normal operation the holding-empty flag reports that nothing is queued, and the interrupt follows that flag. When the programmable mode and the FIFO are both enabled, the holding-empty flag changes meaning and reports that the FIFO is full. In that case the interrupt no longer follows the flag: it fires while the occupancy is at or below a level chosen by a 2-bit select. Any change of the FIFO enable discards the queued characters.

Top module: `uart_tx_empty_status`

## Requirements
- R1: After reset, with the shift register idle, holding-empty and transmitter-empty read 1, and the interrupt is 1 when enabled in normal mode.
- R2: A write strobe adds one entry and a load strobe removes one entry. Capacity is DEPTH (16) with the FIFO enabled and 1 with it disabled. A write to a full queue is dropped unless a load occurs in the same cycle. A load with an empty queue is ignored.
- R3: In normal mode (the programmable mode off, or the FIFO disabled), holding-empty is 1 exactly when the occupancy is zero.
- R4: Transmitter-empty is 1 exactly when the occupancy is zero and the shift-busy input is 0.
- R5: With the programmable mode and the FIFO both enabled, holding-empty is 1 exactly when the occupancy equals DEPTH.
- R6: In normal mode the interrupt equals the interrupt enable ANDed with holding-empty.
- R7: With the programmable mode and the FIFO both enabled, the interrupt equals the interrupt enable ANDed with (occupancy <= level). The threshold select codes 0, 1, 2 and 3 give the levels 0, 2, DEPTH/4 and DEPTH/2.
- R8: With the FIFO disabled, the programmable-mode input and the threshold select have no effect on any output.
- R9: A change of the FIFO enable empties the queue in the same clock edge, and any write or load in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Transmit data write strobe |
| load_i | input | 1 | Shift register load strobe (takes one queued entry) |
| shift_busy_i | input | 1 | Shift register holds a character in flight |
| fifo_en_i | input | 1 | FIFO enable (0 selects the single holding register) |
| prog_en_i | input | 1 | Programmable empty-interrupt mode enable |
| irq_en_i | input | 1 | Transmit-empty interrupt enable |
| thr_sel_i | input | 2 | Interrupt threshold select |
| hold_empty_o | output | 1 | Holding-empty flag (FIFO-full flag in programmable mode) |
| tx_empty_o | output | 1 | Transmitter-empty flag |
| irq_o | output | 1 | Transmit-empty interrupt request |

## Verification
The FIFO is filled one entry at a time up to capacity and beyond, then drained to empty and beyond. This exposes the drop-at-full and ignore-at-empty edges and every occupancy level between them. At each level, all 32 combinations of shift-busy, interrupt enable, programmable mode and threshold select are applied. These sweeps separate the normal and programmable meanings of the flag and show the exact occupancy at which each threshold switches the interrupt. Simultaneous write and load at full, empty and middle occupancy check the push/pop rule. Toggling the FIFO enable with a partly filled queue, and then running the single-register mode with mode inputs swept, separate the flush behaviour and the disabled-FIFO capacity.

// File: rtl/uart_tx_empty_status.sv
module uart_tx_empty_status #(
  parameter int DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       load_i,
  input  logic       shift_busy_i,
  input  logic       fifo_en_i,
  input  logic       prog_en_i,
  input  logic       irq_en_i,
  input  logic [1:0] thr_sel_i,
  output logic       hold_empty_o,
  output logic       tx_empty_o,
  output logic       irq_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt, cap, lvl;
  logic          en_q;

  wire flush = fifo_en_i != en_q;
  wire pop   = load_i && (cnt != '0);
  wire push  = wr_i && ((cnt < cap) || pop);
  wire prog  = prog_en_i && fifo_en_i;

  assign cap = fifo_en_i ? CW'(DEPTH) : CW'(1);

  always_comb begin
    case (thr_sel_i)
      2'd0:    lvl = '0;
      2'd1:    lvl = CW'(2);
      2'd2:    lvl = CW'(DEPTH / 4);
      default: lvl = CW'(DEPTH / 2);
    endcase
  end

  always_ff @(posedge clk_i) begin
    en_q <= fifo_en_i;
    if (!rst_ni || flush) cnt <= '0;
    else                  cnt <= cnt + CW'(push) - CW'(pop);
  end

  assign hold_empty_o = prog ? (cnt == CW'(DEPTH)) : (cnt == '0);
  assign tx_empty_o   = (cnt == '0) && !shift_busy_i;
  assign irq_o        = irq_en_i && (prog ? (cnt <= lvl) : hold_empty_o);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt <= CW'(DEPTH)); // R2
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush && cnt == cap && wr_i && !load_i) |=> $stable(cnt)); // R2
  AST_TEMT_THRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog && tx_empty_o) |-> hold_empty_o); // R4
  AST_PROG_FULL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog && hold_empty_o) |-> !irq_o); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (cnt == '0)); // R9
  AST_SINGLE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !en_q) |-> (cnt <= CW'(1))); // R8
endmodule

// File: tb/uart_tx_empty_status_bench.sv
`timescale 1ns/10ps
module uart_tx_empty_status_bench;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic wr = 0, ld = 0, busy = 0, fen = 1, prog = 0, ien = 0;
  logic [1:0] thr = 0;
  logic hold_e, tx_e, irq;
  int mc = 0, vec = 0, bad = 0;

  always #5 clk = ~clk;

  uart_tx_empty_status #(.DEPTH(DEPTH)) u_uart_tx_empty_status (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .load_i(ld), .shift_busy_i(busy),
    .fifo_en_i(fen), .prog_en_i(prog), .irq_en_i(ien), .thr_sel_i(thr),
    .hold_empty_o(hold_e), .tx_empty_o(tx_e), .irq_o(irq));

  function automatic int level(input logic [1:0] t);
    case (t)
      2'd0: return 0;
      2'd1: return 2;
      2'd2: return DEPTH / 4;
      default: return DEPTH / 2;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    if (act !== exp) begin
      bad++;
      $display("FAIL %s count=%0d fen=%0b prog=%0b thr=%0d busy=%0b ien=%0b: got %0b exp %0b",
               req, mc, fen, prog, thr, busy, ien, act, exp);
    end
  endtask

  task automatic check_now();
    logic pm, eh, et, ei;
    string rh, ri;
    pm = prog && fen;
    eh = pm ? (mc == DEPTH) : (mc == 0);
    et = (mc == 0) && !busy;
    ei = ien && (pm ? (mc <= level(thr)) : eh);
    rh = pm ? "R5" : (fen ? "R3" : "R8");
    ri = pm ? "R7" : (fen ? "R6" : "R8");
    vec++;
    chk(rh, hold_e, eh);
    chk("R4", tx_e, et);
    chk(ri, irq, ei);
  endtask

  task automatic sweep();
    for (int k = 0; k < 32; k++) begin
      {busy, ien, prog, thr} = 5'(k);
      #0.1;
      check_now();
    end
    {busy, ien, prog, thr} = 5'b0;
  endtask

  task automatic cycle(input logic w, input logic l);
    int cap;
    logic p;
    @(negedge clk);
    wr = w; ld = l;
    @(posedge clk);
    cap = fen ? DEPTH : 1;
    p = l && (mc > 0);
    if (w && (mc < cap || p)) mc++;
    if (p) mc--;
    #1 wr = 0; ld = 0;
    sweep();
  endtask

  task automatic toggle_fifo();
    @(negedge clk);
    fen = ~fen; wr = 1; ld = 0;
    @(posedge clk);
    mc = 0;
    #1 wr = 0;
    vec++;
    chk("R9", hold_e, 1'b1);
    chk("R9", tx_e, 1'b1);
    sweep();
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    ien = 1;
    #0.1;
    vec++;
    chk("R1", hold_e, 1'b1);
    chk("R1", tx_e, 1'b1);
    chk("R1", irq, 1'b1);
    ien = 0;
    sweep();
    for (int i = 0; i < DEPTH + 3; i++) cycle(1, 0);          // R2 fill past full
    vec++;
    chk("R2", mc == DEPTH, 1'b1);
    cycle(1, 1);                                              // R2 full: push+pop
    for (int i = 0; i < DEPTH + 2; i++) cycle(0, 1);          // R2 drain past empty
    cycle(1, 1);                                              // R2 empty: only push
    for (int i = 0; i < 4; i++) cycle(1, 0);
    cycle(1, 1);
    toggle_fifo();                                            // R9 to holding mode
    for (int i = 0; i < 3; i++) cycle(1, 0);                  // R8 cap of one
    cycle(1, 1);
    cycle(0, 1);
    cycle(0, 1);
    cycle(1, 0);
    toggle_fifo();                                            // R9 back to FIFO
    for (int i = 0; i < 6; i++) cycle(1, 0);
    for (int i = 0; i < 3; i++) cycle(0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule